// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two operands over many clock cycles. It works on signed or unsigned values, and the operand width is a parameter with a default of 32 bits. The datapath is deliberately small: one operand-wide adder, one multiplicand register and one double-width product register. The multiplier operand has no register of its own. It is loaded into the low half of the product register, and each iteration retires one multiplier bit from the bottom of that register while the partial sum grows in from the top.

A client raises `start` for one cycle while the block is idle, with the operands and the mode select valid on that cycle. `busy` then stays high for the whole operation. A one-cycle `done` pulse marks the point where `hi` and `lo` hold the full product. In signed mode the block multiplies the operand magnitudes and negates the product in a final cycle when the operand signs differ. The result stays on `hi`/`lo` until the next accepted start.

Top module: `shiftadd_mult`

## Requirements
- R1: With `sign_mode`=0, the operands are treated as unsigned values. `{hi,lo}` equals the full 64-bit unsigned product `op_a*op_b` while `done` is high.
- R2: With `sign_mode`=1, the operands are two's-complement values. `{hi,lo}` equals the 64-bit two's-complement product while `done` is high.
- R3: The most negative value (0x80000000) gives a correct signed product in either operand position and in both operand positions at once. For example, 0x80000000*0x80000000 gives 0x4000000000000000.
- R4: `busy` rises on the clock edge that accepts `start` and stays high for exactly 33 cycles. `done` is high in the first cycle after `busy` falls.
- R5: `done` is high for exactly one cycle, and it is never high at the same time as `busy`.
- R6: A `start` pulse that arrives while `busy` is high is ignored. The timing and the result of the operation in flight do not change.
- R7: While the block is idle, `hi` and `lo` keep the last product until the next accepted `start`. A new `start` is accepted in the same cycle as `done`.
- R8: A synchronous active-high `rst` sets `busy` and `done` low and sets `hi` and `lo` to zero.
- R9: The carry out of the adder is kept in every iteration, so products near the full 64-bit range are exact. For example, 0xFFFFFFFF*0xFFFFFFFF unsigned gives 0xFFFFFFFE00000001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when the block is idle |
| sign_mode | input | 1 | 1 = signed operands, 0 = unsigned operands |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| hi | output | 32 | Upper half of the product |
| lo | output | 32 | Lower half of the product |

## Verification
A lost adder carry would corrupt only the products whose partial sums overflow the adder. That error appears in `hi` at the `done` pulse, so the full-range unsigned vectors are the ones that expose it. An iteration counter that is off by one would move `busy` and `done` by one cycle. It would also scale the product by two, and the per-clock comparison of the handshake would catch it on the first operation. A sign flag that is captured badly, or a negation that is skipped, shows up only on signed vectors whose operand signs differ. A start that leaks into a running operation would reload the operand registers, and the wrong result would surface at that operation's `done` pulse.

// File: rtl/shiftadd_pkg.sv
package shiftadd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIX
    } mul_state_e;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_LOAD,
        OP_STEP,
        OP_FIX
    } dp_op_e;

    // Magnitude of a two's-complement value; the most negative value maps to itself,
    // which is its correct magnitude when read as unsigned.
    function automatic logic [63:0] abs_val(input logic [63:0] v, input logic is_neg);
        return is_neg ? (~v + 64'd1) : v;
    endfunction
endpackage

// File: rtl/shiftadd_sign.sv
module shiftadd_sign #(
    parameter int W = 32
) (
    input  logic         sign_mode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] a_mag,
    output logic [W-1:0] b_mag,
    output logic         negate
);
    import shiftadd_pkg::*;

    logic a_neg;
    logic b_neg;
    logic [63:0] a_ext;
    logic [63:0] b_ext;

    always_comb begin
        a_neg  = sign_mode & a[W-1];
        b_neg  = sign_mode & b[W-1];
        a_ext  = 64'(a);
        b_ext  = 64'(b);
        a_mag  = W'(abs_val(a_ext, a_neg));
        b_mag  = W'(abs_val(b_ext, b_neg));
        negate = a_neg ^ b_neg;
    end
endmodule

// File: rtl/shiftadd_ctrl.sv
module shiftadd_ctrl #(
    parameter int W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    output shiftadd_pkg::dp_op_e  op,
    output logic                  busy,
    output logic                  done
);
    import shiftadd_pkg::*;

    localparam int CW = $clog2(W);

    mul_state_e    state;
    logic [CW-1:0] iter;

    always_comb begin
        case (state)
            ST_IDLE: op = start ? OP_LOAD : OP_HOLD;
            ST_RUN:  op = OP_STEP;
            ST_FIX:  op = OP_FIX;
            default: op = OP_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            iter  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RUN;
                    iter  <= '0;
                end
                ST_RUN: begin
                    iter <= iter + 1'b1;
                    if (iter == CW'(W - 1)) state <= ST_FIX;
                end
                ST_FIX: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    // R5
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R4
    start_takes_chk: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
    // R4
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
endmodule

// File: rtl/shiftadd_dp.sv
module shiftadd_dp #(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  shiftadd_pkg::dp_op_e op,
    input  logic [W-1:0]         a_mag,
    input  logic [W-1:0]         b_mag,
    input  logic                 negate,
    output logic [2*W-1:0]       prod
);
    import shiftadd_pkg::*;

    localparam int PW = 2 * W;

    logic [W-1:0] mcand;
    logic         neg_q;
    logic [W:0]   sum;

    // one W-bit adder with its carry kept as bit W
    assign sum = {1'b0, prod[PW-1:W]} + {1'b0, mcand};

    always_ff @(posedge clk) begin
        if (rst) begin
            prod  <= '0;
            mcand <= '0;
            neg_q <= 1'b0;
        end else begin
            case (op)
                OP_LOAD: begin
                    prod  <= {{W{1'b0}}, b_mag};
                    mcand <= a_mag;
                    neg_q <= negate;
                end
                OP_STEP: begin
                    if (prod[0]) prod <= {sum, prod[W-1:1]};
                    else         prod <= {1'b0, prod[PW-1:1]};
                end
                OP_FIX: if (neg_q) prod <= ~prod + 1'b1;
                default: ;
            endcase
        end
    end

    // R9
    noadd_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP && !prod[0]) |=> !prod[PW-1]);
    // R2
    fix_keeps_positive_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_FIX && !neg_q) |=> $stable(prod));
    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(prod));
endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         sign_mode,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    import shiftadd_pkg::*;

    dp_op_e         op;
    logic [W-1:0]   a_mag;
    logic [W-1:0]   b_mag;
    logic           negate;
    logic [2*W-1:0] prod;

    shiftadd_sign #(.W(W)) u_sign (
        .sign_mode(sign_mode), .a(op_a), .b(op_b),
        .a_mag(a_mag), .b_mag(b_mag), .negate(negate)
    );

    shiftadd_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .op(op), .busy(busy), .done(done)
    );

    shiftadd_dp #(.W(W)) u_dp (
        .clk(clk), .rst(rst), .op(op),
        .a_mag(a_mag), .b_mag(b_mag), .negate(negate), .prod(prod)
    );

    assign hi = prod[2*W-1:W];
    assign lo = prod[W-1:0];

    // R6
    busy_ignores_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |-> (op != OP_LOAD));
endmodule

// File: tb/shiftadd_mult_bench.sv
`timescale 1ns/1ps
module shiftadd_mult_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        sign_mode;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic        busy;
    logic        done;
    logic [31:0] hi;
    logic [31:0] lo;

    int vectors = 0;
    int errors  = 0;
    string tag = "R8";

    // reference model state
    int          m_left = 0;
    logic        m_done = 1'b0;
    logic [63:0] m_pend = '0;
    logic [63:0] m_res  = '0;
    logic        model_on = 1'b0;

    always #2 clk = ~clk;

    shiftadd_mult u_shiftadd_mult (
        .clk(clk), .rst(rst), .start(start), .sign_mode(sign_mode),
        .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b, input logic s);
        longint sa;
        longint sb;
        if (s) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            return 64'(sa * sb);
        end
        return {32'd0, a} * {32'd0, b};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_left = 0; m_done = 1'b0; m_res = '0;
        end else begin
            m_done = 1'b0;
            if (m_left > 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_done = 1'b1;
                    m_res  = m_pend;
                end
            end else if (start) begin
                m_left = 33;
                m_pend = ref_prod(op_a, op_b, sign_mode);
            end
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            vectors++;
            if (busy !== (m_left > 0)) begin
                errors++;
                $display("FAIL R4 busy actual=%b expected=%b", busy, (m_left > 0));
            end
            vectors++;
            if (done !== m_done) begin
                errors++;
                $display("FAIL R5 done actual=%b expected=%b", done, m_done);
            end
            if (m_left == 0) begin
                vectors++;
                if ({hi, lo} !== m_res) begin
                    errors++;
                    $display("FAIL %s result actual=%h expected=%h", tag, {hi, lo}, m_res);
                end
            end
        end
    end

    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic s, input string t);
        @(negedge clk);
        tag = t; op_a = a; op_b = b; sign_mode = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
    endtask

    initial begin
        logic [31:0] lf;
        rst = 1'b1; start = 1'b0; sign_mode = 1'b0; op_a = '0; op_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_on = 1'b1;
        repeat (3) @(negedge clk);   // R8 reset state compared by model

        run(32'd6, 32'd7, 1'b0, "R1");
        run(32'h0001_0000, 32'h0001_0000, 1'b0, "R1");
        run(32'hDEAD_BEEF, 32'h1234_5678, 1'b0, "R1");
        run(32'd0, 32'h8765_4321, 1'b0, "R1");
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R9");
        run(32'hFFFF_FFFF, 32'h8000_0001, 1'b0, "R9");
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R2");
        run(32'hFFFF_FFF9, 32'd2, 1'b1, "R2");
        run(32'd3, 32'hFFFF_FFFB, 1'b1, "R2");
        run(32'h8000_0000, 32'h8000_0000, 1'b1, "R3");
        run(32'h8000_0000, 32'd1, 1'b1, "R3");
        run(32'hFFFF_FFFF, 32'h8000_0000, 1'b1, "R3");
        run(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, "R3");

        // R6: extra start pulses during a run
        @(negedge clk);
        tag = "R6"; op_a = 32'd12345; op_b = 32'd777; sign_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        op_a = 32'hFFFF_0000; op_b = 32'h1111; sign_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);

        // R7: hold while idle, then restart in the done cycle
        tag = "R7";
        repeat (8) @(negedge clk);
        op_a = 32'd1000; op_b = 32'd1000; sign_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        op_a = 32'hFFFF_FFFE; op_b = 32'd3; sign_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);

        lf = 32'hACE1_1234;
        for (int i = 0; i < 20; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            run(lf, {lf[15:0], lf[31:16]} ^ 32'h5A5A_A5A5, lf[3], lf[3] ? "R2" : "R1");
        end
        repeat (4) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule